// File: doc/BRIEF.md
# Expansion Bus 32-bit Slave Cycle Controller

This block is the slave side of an EISA-style expansion bus cycle, clocked by the bus clock. At every rising edge it watches the phase strobes, the space select, the direction line, the latched word address and the four active-low byte enables. When the start strobe is sampled low, it compares the address with a programmable base/mask window and the space select with a programmable space. On a match it claims the cycle. It then advertises its data width and its burst capability, and it runs the command phase against a small local word store.

Wait states come from a configurable count of 0 to 7. For that many bus clocks the ready line is held low after the start edge, and again after each burst beat. Then the ready line is released for exactly one clock, and the beat completes at the following edge. On a write, only the enabled byte lanes of the addressed word are stored. On a read, the stored word is presented together with a data-enable output for as long as the command phase of the claimed cycle lasts. Burst continues for as long as the master answers the burst offer at each completing edge. The master presents the next word address at that same edge.

All bus signals are plain levels, so there is no valid/ready stream at the edge. Back-pressure toward the master is given only by the ready line.

Top module: `ebus_slave_port`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. The next cycle shows `ex32_n`=1, `ex16_n`=1, `slburst_n`=1, `exrdy`=1 and `rdata_oe`=0.
- R2: A cycle is claimed only when `start_n`=0 is sampled with `mio` equal to `cfg_mem` (`mio`=1 means memory) and `((la ^ cfg_base) & cfg_mask) == 0`. An unclaimed cycle leaves every bus output released and never drives data.
- R3: A claimed cycle asserts `ex32_n` low (or `ex16_n` low when `WIDE32`=0) from the clock after the start edge until the cycle ends. The two are never low together.
- R4: After the start edge, and after every burst beat, `exrdy` is low for exactly `cfg_waits` clocks. It is then high for one clock, and the beat completes at the next rising edge with `cmd_n`=0. `exrdy` is high whenever no cycle is claimed.
- R5: At a write completion (`wr_rd`=1), byte lane i (`wdata[8i+7:8i]`) of the word at index `la[IDX_W-1:0]` is updated only if `be_n[i]`=0. The other lanes keep their value.
- R6: `rdata_oe` is 1 only during the command phase of a claimed read cycle. While it is 1, `rdata` equals the stored word at the latched index.
- R7: While a cycle is claimed, `slburst_n` is low. If `msburst_n`=0 at a completing edge, the cycle stays claimed, `la` at that edge becomes the next word address, and the wait count reloads. Otherwise the cycle ends at that edge.
- R8: If `cmd_n` is sampled high while a cycle is claimed, the cycle ends at that edge. No data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Start phase strobe, low active |
| cmd_n | input | 1 | Command phase strobe, low active |
| mio | input | 1 | Space select, 1 memory, 0 I/O |
| wr_rd | input | 1 | Direction, 1 write, 0 read |
| la | input | AW | Word address (byte address bits above 1) |
| be_n | input | 4 | Byte lane enables, low active |
| msburst_n | input | 1 | Master burst answer, low active |
| wdata | input | 32 | Write data from the bus |
| cfg_base | input | AW | Window base word address |
| cfg_mask | input | AW | Window compare mask |
| cfg_mem | input | 1 | Space the window answers in |
| cfg_waits | input | WW | Wait states per beat |
| ex32_n | output | 1 | 32-bit claim, low active |
| ex16_n | output | 1 | 16-bit claim, low active |
| slburst_n | output | 1 | Slave burst offer, low active |
| exrdy | output | 1 | Ready, low inserts wait states |
| rdata | output | 32 | Read data to the bus |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The bench goes after four failure modes. The first is an address differing from the window in a single masked bit, or a cycle in the wrong space: a loose decoder would claim it and drive data. The second is a wait count off by one in either direction, which shows up as a wrong number of low ready clocks, including the zero-wait case. The third is a partial byte enable pattern: a design that ignores lanes would overwrite neighbouring bytes, and later reads expose this. The last covers multi-beat bursts and command-phase aborts. A design that latched the next address at the wrong edge would read or write the wrong word, and one that kept a cycle alive after an abort would keep claiming or would store data.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } bus_st_t;

  localparam int LANES = 4;
  localparam int LANE_W = 8;
endpackage

// File: rtl/ebus_decode.sv
module ebus_decode #(
  parameter int AW = 30
) (
  input  logic [AW-1:0] la,
  input  logic          mio,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic          space,
  output logic          hit
);
  logic [AW-1:0] diff;

  always_comb begin
    diff = (la ^ base) & mask;
    hit  = (mio == space) && (diff == '0);
  end
endmodule

// File: rtl/ebus_waitgen.sv
module ebus_waitgen #(
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [WW-1:0] waits,
  output logic          rdy
);
  logic [WW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rdy_q <= 1'b1;
    end else if (load) begin
      cnt_q <= waits;
      rdy_q <= (waits == '0);
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
      rdy_q <= (cnt_q == {{(WW-1){1'b0}}, 1'b1});
    end
  end

  assign rdy = rdy_q;
endmodule

// File: rtl/ebus_store.sv
module ebus_store
  import ebus_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IW-1:0]          idx,
  input  logic [LANES-1:0]       be_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) bytes_q[i] <= '0;
      end else if (we && !be_n[l]) begin
        bytes_q[idx] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = bytes_q[idx];
  end
endmodule

// File: rtl/ebus_slave_port.sv
module ebus_slave_port
  import ebus_pkg::*;
#(
  parameter int AW       = 30,
  parameter int DEPTH    = 16,
  parameter int WW       = 3,
  parameter bit WIDE32   = 1'b1,
  parameter bit BURST_EN = 1'b1,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_n,
  input  logic          cmd_n,
  input  logic          mio,
  input  logic          wr_rd,
  input  logic [AW-1:0] la,
  input  logic [3:0]    be_n,
  input  logic          msburst_n,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_mask,
  input  logic          cfg_mem,
  input  logic [WW-1:0] cfg_waits,
  output logic          ex32_n,
  output logic          ex16_n,
  output logic          slburst_n,
  output logic          exrdy,
  output logic [31:0]   rdata,
  output logic          rdata_oe
);
  bus_st_t          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             wr_q;
  logic             hit;
  logic             rdy;
  logic             claimed;
  logic             start_hit;
  logic             beat_done;
  logic             burst_go;
  logic             load_w;
  logic             step_w;

  ebus_decode #(.AW(AW)) u_dec (
    .la    (la),
    .mio   (mio),
    .base  (cfg_base),
    .mask  (cfg_mask),
    .space (cfg_mem),
    .hit   (hit)
  );

  always_comb begin
    claimed   = (st_q == ST_XFER);
    start_hit = (st_q == ST_IDLE) && !start_n && hit;
    beat_done = claimed && !cmd_n && rdy;
    burst_go  = beat_done && !msburst_n && BURST_EN;
    load_w    = start_hit || burst_go;
    step_w    = claimed && !cmd_n && !rdy;
  end

  ebus_waitgen #(.WW(WW)) u_wait (
    .clk   (clk),
    .rst   (rst),
    .load  (load_w),
    .step  (step_w),
    .waits (cfg_waits),
    .rdy   (rdy)
  );

  ebus_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (beat_done && wr_q),
    .idx   (idx_q),
    .be_n  (be_n),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_hit) begin
            st_q  <= ST_XFER;
            idx_q <= la[IDX_W-1:0];
            wr_q  <= wr_rd;
          end
        end
        ST_XFER: begin
          if (cmd_n) begin
            st_q <= ST_IDLE;
          end else if (burst_go) begin
            idx_q <= la[IDX_W-1:0];
          end else if (beat_done) begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  if (WIDE32) begin : g_w32
    assign ex32_n = !claimed;
    assign ex16_n = 1'b1;
  end else begin : g_w16
    assign ex32_n = 1'b1;
    assign ex16_n = !claimed;
  end

  assign slburst_n = !(claimed && BURST_EN);
  assign exrdy     = !claimed || rdy;
  assign rdata_oe  = claimed && !wr_q;
endmodule

// File: rtl/ebus_slave_chk.sv
module ebus_slave_chk (
  input logic clk,
  input logic rst,
  input logic start_n,
  input logic cmd_n,
  input logic ex32_n,
  input logic ex16_n,
  input logic slburst_n,
  input logic exrdy,
  input logic rdata_oe
);
  logic claim;
  assign claim = !(ex32_n && ex16_n);

  assert_reset_release_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ex32_n && ex16_n && slburst_n && exrdy && !rdata_oe));

  assert_claim_after_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(claim) |-> $past(!start_n));

  assert_single_width_R3: assert property (@(posedge clk) disable iff (rst)
    !(!ex32_n && !ex16_n));

  assert_idle_ready_R4: assert property (@(posedge clk) disable iff (rst)
    !claim |-> exrdy);

  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (claim && !cmd_n && !exrdy) |=> claim);

  assert_oe_claimed_R6: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> claim);

  assert_burst_claimed_R7: assert property (@(posedge clk) disable iff (rst)
    !slburst_n |-> claim);

  assert_abort_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (claim && cmd_n) |=> !claim);
endmodule

bind ebus_slave_port ebus_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_n   (start_n),
  .cmd_n     (cmd_n),
  .ex32_n    (ex32_n),
  .ex16_n    (ex16_n),
  .slburst_n (slburst_n),
  .exrdy     (exrdy),
  .rdata_oe  (rdata_oe)
);

// File: tb/sim_ebus_slave_port.sv
`timescale 1ns/1ps
module sim_ebus_slave_port;
  localparam logic [29:0] BASE = 30'h0001_2340;
  localparam logic [29:0] MASK = 30'h3FFF_FFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_n = 1'b1, cmd_n = 1'b1, mio = 1'b1, wr_rd = 1'b0;
  logic [29:0] la = '0;
  logic [3:0]  be_n = 4'hF;
  logic        msburst_n = 1'b1;
  logic [31:0] wdata = '0;
  logic [2:0]  cfg_waits = '0;
  logic        ex32_n, ex16_n, slburst_n, exrdy, rdata_oe;
  logic [31:0] rdata;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] model [16];

  always #2.5 clk = ~clk;

  ebus_slave_port u0 (
    .clk(clk), .rst(rst), .start_n(start_n), .cmd_n(cmd_n), .mio(mio),
    .wr_rd(wr_rd), .la(la), .be_n(be_n), .msburst_n(msburst_n),
    .wdata(wdata), .cfg_base(BASE), .cfg_mask(MASK), .cfg_mem(1'b1),
    .cfg_waits(cfg_waits), .ex32_n(ex32_n), .ex16_n(ex16_n),
    .slburst_n(slburst_n), .exrdy(exrdy), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_merge(input logic [31:0] old,
      input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (!be[l]) r[l*8 +: 8] = d[l*8 +: 8];
    return r;
  endfunction

  function automatic bit exp_hit(input logic [29:0] a, input logic m);
    return m && (((a ^ BASE) & MASK) == '0);
  endfunction

  task automatic wait_ready(input int ws, input logic w, input int idx, input string tag);
    int n = 0;
    while (exrdy == 1'b0 && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == ws, "R4 wait count", 32'(n), 32'(ws));
    if (!w) chk(rdata_oe && rdata == model[idx], tag, rdata, model[idx]);
    else chk(rdata_oe == 1'b0, "R6 oe on write", 32'(rdata_oe), 0);
  endtask

  task automatic cycle(input logic [29:0] a, input logic m, input logic w,
                       input logic [3:0] be, input logic [31:0] d,
                       input logic [2:0] ws, input string tag);
    bit h = exp_hit(a, m);
    int idx = int'(a[3:0]);
    @(negedge clk);
    start_n = 0; cmd_n = 1; la = a; mio = m; wr_rd = w; be_n = be;
    wdata = d; cfg_waits = ws; msburst_n = 1;
    @(negedge clk);
    start_n = 1; cmd_n = 0;
    chk(ex32_n == !h, "R2/R3 claim", 32'(ex32_n), 32'(!h));
    chk(ex16_n == 1'b1, "R3 ex16 idle", 32'(ex16_n), 1);
    chk(slburst_n == !h, "R7 burst offer", 32'(slburst_n), 32'(!h));
    if (!h) begin
      chk(exrdy && !rdata_oe, "R2 miss quiet", {exrdy, rdata_oe}, 32'b10);
      @(negedge clk);
      cmd_n = 1;
      return;
    end
    wait_ready(int'(ws), w, idx, tag);
    @(negedge clk);
    if (w) model[idx] = lane_merge(model[idx], d, be);
    cmd_n = 1;
    chk(ex32_n && exrdy && !rdata_oe, "R3 release", {ex32_n, exrdy, rdata_oe}, 32'b110);
  endtask

  task automatic burst(input logic w, input int i0, input int nb, input logic [2:0] ws);
    logic [3:0]  be;
    logic [31:0] d;
    @(negedge clk);
    start_n = 0; cmd_n = 1; la = BASE | 30'(i0); mio = 1; wr_rd = w;
    cfg_waits = ws; msburst_n = 1;
    @(negedge clk);
    start_n = 1; cmd_n = 0;
    for (int k = 0; k < nb; k++) begin
      int idx = (i0 + k) % 16;
      be = 4'($urandom); d = $urandom;
      be_n = be; wdata = d;
      wait_ready(int'(ws), w, idx, "R7 burst read");
      if (k < nb - 1) begin
        msburst_n = 0; la = BASE | 30'((i0 + k + 1) % 16);
      end
      @(negedge clk);
      if (w) model[idx] = lane_merge(model[idx], d, be);
      msburst_n = 1;
      if (k < nb - 1) chk(ex32_n == 1'b0, "R7 burst held", 32'(ex32_n), 0);
      else chk(ex32_n == 1'b1, "R7 burst end", 32'(ex32_n), 1);
    end
    cmd_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ex32_n && ex16_n && slburst_n && exrdy && !rdata_oe, "R1 reset",
        {ex32_n, ex16_n, slburst_n, exrdy, rdata_oe}, 32'b11110);

    // directed: lane-selective writes and zero / max waits
    cycle(BASE | 30'd3, 1, 1, 4'h0, 32'hA1B2C3D4, 3'd0, "R5");
    cycle(BASE | 30'd3, 1, 1, 4'b1010, 32'h11223344, 3'd7, "R5");
    cycle(BASE | 30'd3, 1, 0, 4'h0, 32'h0, 3'd2, "R5 lane readback");
    // directed misses: one masked bit off, wrong space
    cycle(BASE ^ 30'h10, 1, 1, 4'h0, 32'hDEADBEEF, 3'd1, "R2");
    cycle(BASE | 30'd5, 0, 1, 4'h0, 32'hDEADBEEF, 3'd1, "R2");
    cycle(BASE | 30'd5, 1, 0, 4'h0, 32'h0, 3'd0, "R2 miss left store");

    // abort mid-wait
    @(negedge clk);
    start_n = 0; cmd_n = 1; la = BASE | 30'd9; mio = 1; wr_rd = 1;
    be_n = 4'h0; wdata = 32'hCAFEF00D; cfg_waits = 3'd5;
    @(negedge clk); start_n = 1; cmd_n = 0;
    @(negedge clk); cmd_n = 1;
    @(negedge clk);
    chk(ex32_n && exrdy, "R8 abort release", {ex32_n, exrdy}, 32'b11);
    cycle(BASE | 30'd9, 1, 0, 4'h0, 32'h0, 3'd0, "R8 no store");

    // bursts
    burst(1, 14, 4, 3'd1);
    burst(0, 14, 4, 3'd0);
    burst(0, 15, 2, 3'd3);

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [29:0] a;
      logic m = ($urandom % 5) != 0;
      if ($urandom % 4 == 0) a = BASE ^ (30'h10 << ($urandom % 20));
      else a = BASE | 30'($urandom % 16);
      cycle(a, m, 1'($urandom), 4'($urandom), $urandom, 3'($urandom), "R6 read");
    end

    // reset during a claimed cycle
    @(negedge clk);
    start_n = 0; cmd_n = 1; la = BASE; mio = 1; wr_rd = 0; cfg_waits = 3'd4;
    @(negedge clk); start_n = 1; cmd_n = 0; rst = 1;
    @(negedge clk); rst = 0; cmd_n = 1;
    chk(ex32_n && slburst_n && exrdy && !rdata_oe, "R1 reset mid-cycle",
        {ex32_n, slburst_n, exrdy, rdata_oe}, 32'b1110);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule